// File: doc/BRIEF.md
# Remote-Call Message Queue with Hint Prefetch

This block sits in one memory partition and collects incoming non-blocking remote-call packets so the local core can run them in batches rather than being interrupted once per call. Each packet holds a function code, an argument word and an optional hint address. When a packet with a valid hint is accepted, the queue sends a prefetch request for that address toward local memory. The packet becomes ready to run only once the matching prefetch response has come back. A packet without a hint is ready at once.

The core is interrupted when the number of ready packets rises above a programmable threshold. It is also interrupted when the queue is full, or while a barrier is being drained. The core pulls ready packets one at a time through a valid/ready dequeue port, oldest first among the ready ones. It runs each call to completion before it takes the next. The queue never preempts a call and never drops a packet. Prefetch requests are tagged with the slot index that holds the packet, so responses may come back in any order. A barrier pulse stops new packets from entering until every queued packet has been pulled. A one-cycle acknowledge then marks that the barrier has drained.

Top module: `rcall_queue`

## Requirements
- R1: After reset, `in_ready` is 1 and `irq`, `out_valid`, `pf_req_valid` and `barrier_done` are all 0.
- R2: An accepted packet whose `in_hint_vld` is 1 produces exactly one prefetch request. The request carries the packet's hint address on `pf_req_addr` and the index of its slot on `pf_req_tag`. The request is held until `pf_req_ready` is 1. The packet is not ready before the response arrives.
- R3: A response with `pf_rsp_valid` high marks ready only the packet whose slot index equals `pf_rsp_tag`, starting on the next cycle. Responses may arrive in any order.
- R4: While `irq_en` is 1, `irq` is high whenever the count of ready packets is strictly greater than `ready_thresh`. It falls once the count is at or below the threshold, provided the queue is not full and no barrier is pending.
- R5: An accepted packet whose `in_hint_vld` is 0 issues no prefetch and is ready on the cycle after it is accepted.
- R6: `out_valid` is 1 whenever any packet is ready. `out_func` and `out_arg` then show the oldest ready packet, and it is removed when `out_ready` is also 1.
- R7: When all slots are occupied, `in_ready` is 0 and no packet is lost. If `irq_en` is 1, `irq` is also high for as long as the queue stays full.
- R8: A `barrier` pulse makes the barrier pending from the next cycle. While it is pending, `in_ready` is 0, and `irq` stays high (with `irq_en` at 1) as long as any packet is still queued.
- R9: `barrier_done` is high for exactly one cycle, namely the first cycle in which a barrier is pending and the queue is empty. The barrier is then no longer pending.
- R10: While `irq_en` is 0, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet valid |
| in_ready | output | 1 | Queue can accept a packet |
| in_func | input | FN_W | Function code of the incoming packet |
| in_arg | input | ARG_W | Argument of the incoming packet |
| in_hint_vld | input | 1 | Incoming packet carries a hint address |
| in_hint_addr | input | ADDR_W | Hint address to prefetch |
| pf_req_valid | output | 1 | Prefetch request valid |
| pf_req_ready | input | 1 | Memory accepts the prefetch request |
| pf_req_addr | output | ADDR_W | Prefetch address |
| pf_req_tag | output | log2(DEPTH) | Slot index carried with the request |
| pf_rsp_valid | input | 1 | Prefetch response valid |
| pf_rsp_tag | input | log2(DEPTH) | Slot index of the completed prefetch |
| irq_en | input | 1 | Interrupt enable |
| ready_thresh | input | log2(DEPTH+1) | Ready-count threshold for the interrupt |
| barrier | input | 1 | Barrier request pulse |
| barrier_done | output | 1 | Barrier drained acknowledge |
| irq | output | 1 | Interrupt to the core |
| out_valid | output | 1 | A ready packet is available |
| out_ready | input | 1 | Core takes the offered packet |
| out_func | output | FN_W | Function code of the offered packet |
| out_arg | output | ARG_W | Argument of the offered packet |

## Verification
The bench keeps a reference queue ordered by arrival and compares the block's outputs against it on every cycle. Random traffic mixes hinted and unhinted packets, with memory latencies of 1 to 24 cycles and random response order. This separates oldest-ready selection from plain arrival order and from slot-index order, and shows that each response affects only its own tagged slot. A directed fill with the core stalled tells full-queue back-pressure and the full interrupt apart from the threshold interrupt. Sweeps of the threshold and of the enable, together with barrier pulses sent at random times and while packets are still waiting on prefetches, separate the three interrupt causes and check the barrier acknowledge timing.

// File: rtl/rcall_queue.sv
module rcall_queue #(
  parameter int DEPTH  = 8,
  parameter int FN_W   = 8,
  parameter int ARG_W  = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FN_W-1:0]   in_func,
  input  logic [ARG_W-1:0]  in_arg,
  input  logic              in_hint_vld,
  input  logic [ADDR_W-1:0] in_hint_addr,
  output logic              pf_req_valid,
  input  logic              pf_req_ready,
  output logic [ADDR_W-1:0] pf_req_addr,
  output logic [IDX_W-1:0]  pf_req_tag,
  input  logic              pf_rsp_valid,
  input  logic [IDX_W-1:0]  pf_rsp_tag,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  ready_thresh,
  input  logic              barrier,
  output logic              barrier_done,
  output logic              irq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FN_W-1:0]   out_func,
  output logic [ARG_W-1:0]  out_arg
);

  logic [FN_W-1:0]   fn_q   [DEPTH];
  logic [ARG_W-1:0]  arg_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  older  [DEPTH];
  logic [DEPTH-1:0]  occ, rdy, pend;
  logic              bar_act;

  logic [IDX_W-1:0]  free_idx, pf_idx, out_idx;
  logic [CNT_W-1:0]  cnt, rcnt;
  logic              enq, deq, pf_go, rsp_hit;

  always_comb begin
    free_idx = '0;
    pf_idx   = '0;
    out_idx  = '0;
    cnt      = '0;
    rcnt     = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) free_idx = IDX_W'(i);
      if (pend[i]) pf_idx = IDX_W'(i);
      if (rdy[i] && ((older[i] & rdy) == '0)) out_idx = IDX_W'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      cnt  = cnt + CNT_W'(occ[i]);
      rcnt = rcnt + CNT_W'(rdy[i]);
    end
  end

  wire full  = (cnt == CNT_W'(DEPTH));
  wire empty = (cnt == '0);

  assign in_ready     = !full && !bar_act;
  assign enq          = in_valid && in_ready;
  assign out_valid    = |rdy;
  assign deq          = out_valid && out_ready;
  assign out_func     = fn_q[out_idx];
  assign out_arg      = arg_q[out_idx];
  assign pf_req_valid = |pend;
  assign pf_req_addr  = addr_q[pf_idx];
  assign pf_req_tag   = pf_idx;
  assign pf_go        = pf_req_valid && pf_req_ready;
  assign rsp_hit      = pf_rsp_valid && occ[pf_rsp_tag] && !rdy[pf_rsp_tag] && !pend[pf_rsp_tag];
  assign barrier_done = bar_act && empty;
  assign irq          = irq_en && ((rcnt > ready_thresh) || full || (bar_act && !empty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ     <= '0;
      rdy     <= '0;
      pend    <= '0;
      bar_act <= 1'b0;
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else begin
      if (deq) begin
        occ[out_idx] <= 1'b0;
        rdy[out_idx] <= 1'b0;
      end
      if (pf_go) pend[pf_idx] <= 1'b0;
      if (rsp_hit) rdy[pf_rsp_tag] <= 1'b1;
      if (enq) begin
        occ[free_idx]  <= 1'b1;
        rdy[free_idx]  <= !in_hint_vld;
        pend[free_idx] <= in_hint_vld;
        for (int j = 0; j < DEPTH; j++) older[j][free_idx] <= 1'b0;
        older[free_idx] <= occ & ~(deq ? (DEPTH'(1) << out_idx) : '0);
      end
      if (!bar_act && barrier) bar_act <= 1'b1;
      else if (barrier_done)   bar_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      fn_q[free_idx]   <= in_func;
      arg_q[free_idx]  <= in_arg;
      addr_q[free_idx] <= in_hint_addr;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && !pf_req_valid && !barrier_done); // R1
  AST_PF_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n) pf_req_valid |-> occ[pf_req_tag] && !rdy[pf_req_tag]); // R2
  AST_RSP_MARKS: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |=> out_valid); // R3
  AST_IRQ_THRESH: assert property (@(posedge clk) disable iff (!rst_n) irq_en && (rcnt > ready_thresh) |-> irq); // R4
  AST_NOHINT_READY: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready && !in_hint_vld |=> out_valid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt == CNT_W'(DEPTH) |-> !in_ready); // R7
  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bar_act && !empty && irq_en |-> irq && !in_ready); // R8
  AST_BAR_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) barrier_done |=> !barrier_done); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R10

endmodule

// File: tb/rcall_queue_tb.sv
module rcall_queue_tb;
  localparam int DEPTH = 8;
  localparam int FN_W = 8, ARG_W = 32, ADDR_W = 32;
  localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_hint_vld = 0;
  logic [FN_W-1:0] in_func = '0;
  logic [ARG_W-1:0] in_arg = '0;
  logic [ADDR_W-1:0] in_hint_addr = '0;
  logic pf_req_valid, pf_req_ready = 0, pf_rsp_valid = 0;
  logic [ADDR_W-1:0] pf_req_addr;
  logic [IDX_W-1:0] pf_req_tag, pf_rsp_tag = '0;
  logic irq_en = 0, barrier = 0, barrier_done, irq, out_valid, out_ready = 0;
  logic [CNT_W-1:0] ready_thresh = '0;
  logic [FN_W-1:0] out_func;
  logic [ARG_W-1:0] out_arg;

  always #4 clk = ~clk;

  rcall_queue #(.DEPTH(DEPTH), .FN_W(FN_W), .ARG_W(ARG_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_func(in_func),
    .in_arg(in_arg), .in_hint_vld(in_hint_vld), .in_hint_addr(in_hint_addr),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready), .pf_req_addr(pf_req_addr),
    .pf_req_tag(pf_req_tag), .pf_rsp_valid(pf_rsp_valid), .pf_rsp_tag(pf_rsp_tag),
    .irq_en(irq_en), .ready_thresh(ready_thresh), .barrier(barrier), .barrier_done(barrier_done),
    .irq(irq), .out_valid(out_valid), .out_ready(out_ready), .out_func(out_func), .out_arg(out_arg));

  int total = 0, bad = 0;
  bit finished = 0;

  // reference queue, arrival order
  logic [FN_W-1:0]   m_fn [DEPTH];
  logic [ARG_W-1:0]  m_arg[DEPTH];
  logic [ADDR_W-1:0] m_ha [DEPTH];
  bit m_hv[DEPTH], m_rd[DEPTH], m_is[DEPTH];
  int m_n = 0;
  bit bar_m = 0;
  // outstanding prefetches in the memory model
  logic [ADDR_W-1:0] p_addr[16];
  logic [IDX_W-1:0]  p_tag[16];
  int p_dly[16];
  int p_n = 0;
  int seq = 0;
  int k_in = 50, k_hint = 50, k_out = 50, k_pf = 70, k_bar = 0;
  bit force_bar = 0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic int n_ready();
    int c = 0;
    for (int i = 0; i < m_n; i++) c += int'(m_rd[i]);
    return c;
  endfunction

  function automatic int first_ready();
    for (int i = 0; i < m_n; i++) if (m_rd[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_irq();
    return irq_en && ((n_ready() > int'(ready_thresh)) || (m_n == DEPTH) || (bar_m && m_n != 0));
  endfunction

  function automatic bit want_pf();
    for (int i = 0; i < m_n; i++) if (m_hv[i] && !m_is[i]) return 1;
    return 0;
  endfunction

  task automatic step();
    bit enq, deq, pfg, rsp, bset, bclr;
    int fr, rk, hit;
    @(negedge clk);
    chk(in_ready == ((m_n < DEPTH) && !bar_m), bar_m ? "R8 in_ready" : "R7 in_ready", in_ready, (m_n < DEPTH) && !bar_m);
    chk(barrier_done == (bar_m && m_n == 0), "R9 barrier_done", barrier_done, bar_m && m_n == 0);
    chk(pf_req_valid == want_pf(), "R2 pf_req_valid", pf_req_valid, want_pf());
    if (pf_req_valid) begin
      hit = -1;
      for (int i = 0; i < m_n; i++) if (m_hv[i] && !m_is[i] && m_ha[i] == pf_req_addr) hit = i;
      chk(hit >= 0, "R2 pf_req_addr", pf_req_addr, 0);
    end
    in_valid     = ($urandom % 100) < k_in;
    in_hint_vld  = ($urandom % 100) < k_hint;
    in_func      = FN_W'($urandom);
    in_arg       = $urandom;
    in_hint_addr = in_hint_vld ? ADDR_W'(32'h4000_0000 + seq * 64) : ADDR_W'($urandom);
    pf_req_ready = ($urandom % 100) < k_pf;
    out_ready    = ($urandom % 100) < k_out;
    barrier      = force_bar || (($urandom % 1000) < k_bar);
    force_bar    = 0;
    rk = -1;
    for (int i = 0; i < p_n; i++) begin
      if (p_dly[i] > 0) p_dly[i]--;
      if (p_dly[i] == 0 && (rk < 0 || ($urandom % 2) == 1)) rk = i;
    end
    pf_rsp_valid = (rk >= 0);
    pf_rsp_tag   = (rk >= 0) ? p_tag[rk] : IDX_W'($urandom);
    #1;
    chk(irq == exp_irq(), irq_en ? "R4 irq" : "R10 irq", irq, exp_irq());
    chk(out_valid == (n_ready() > 0), "R3/R5 out_valid", out_valid, n_ready() > 0);
    fr = first_ready();
    if (out_valid && out_ready && fr >= 0)
      chk(out_func == m_fn[fr] && out_arg == m_arg[fr], "R6 out data", {out_func, out_arg}, {m_fn[fr], m_arg[fr]});
    enq  = in_valid && in_ready;
    deq  = out_valid && out_ready && fr >= 0;
    pfg  = pf_req_valid && pf_req_ready;
    rsp  = pf_rsp_valid;
    bset = !bar_m && barrier;
    bclr = bar_m && m_n == 0;
    @(posedge clk);
    if (rsp) begin
      for (int i = 0; i < m_n; i++) if (m_hv[i] && m_is[i] && m_ha[i] == p_addr[rk]) m_rd[i] = 1;
      for (int i = rk; i < p_n - 1; i++) begin
        p_addr[i] = p_addr[i+1]; p_tag[i] = p_tag[i+1]; p_dly[i] = p_dly[i+1];
      end
      p_n--;
    end
    if (pfg) begin
      for (int i = 0; i < m_n; i++) if (m_hv[i] && !m_is[i] && m_ha[i] == pf_req_addr) m_is[i] = 1;
      p_addr[p_n] = pf_req_addr; p_tag[p_n] = pf_req_tag; p_dly[p_n] = 1 + int'($urandom % 24);
      p_n++;
    end
    if (deq) begin
      for (int i = fr; i < m_n - 1; i++) begin
        m_fn[i] = m_fn[i+1]; m_arg[i] = m_arg[i+1]; m_ha[i] = m_ha[i+1];
        m_hv[i] = m_hv[i+1]; m_rd[i] = m_rd[i+1]; m_is[i] = m_is[i+1];
      end
      m_n--;
    end
    if (enq) begin
      m_fn[m_n] = in_func; m_arg[m_n] = in_arg; m_ha[m_n] = in_hint_addr;
      m_hv[m_n] = in_hint_vld; m_rd[m_n] = !in_hint_vld; m_is[m_n] = 0;
      m_n++;
      seq++;
    end
    if (bset) bar_m = 1;
    else if (bclr) bar_m = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !irq && !out_valid && !pf_req_valid && !barrier_done, "R1 reset state",
        {in_ready, irq, out_valid, pf_req_valid, barrier_done}, 5'b10000);
    // directed fill with a stalled core: full back-pressure and full interrupt
    irq_en = 1; ready_thresh = CNT_W'(DEPTH);
    k_in = 100; k_out = 0; k_pf = 100;
    repeat (40) step();
    k_out = 100; k_in = 0;
    repeat (60) step();
    // threshold sweep with unhinted packets only
    k_hint = 0; k_in = 60; k_out = 20;
    for (int t = 0; t <= DEPTH; t++) begin
      ready_thresh = CNT_W'(t);
      repeat (60) step();
    end
    // barrier with prefetches still pending
    k_hint = 100; k_in = 100; k_out = 0; k_pf = 40;
    repeat (6) step();
    force_bar = 1; k_in = 0; k_out = 60;
    repeat (80) step();
    // random mix
    k_hint = 50; k_bar = 8;
    for (int r = 0; r < 30; r++) begin
      irq_en = ($urandom % 4) != 0;
      ready_thresh = CNT_W'($urandom % (DEPTH + 1));
      k_in = 20 + int'($urandom % 80); k_out = int'($urandom % 100); k_pf = 20 + int'($urandom % 80);
      repeat (150) step();
    end
    // drain
    k_in = 0; k_out = 100; k_pf = 100; k_bar = 0;
    repeat (80) step();
    chk(!out_valid && !pf_req_valid, "R6 drained", {out_valid, pf_req_valid}, 2'b00);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule